// File: doc/BRIEF.md
# Wake Event Collector and Power-Management Event Signalling

This block gathers three wake-up requests from elsewhere in a network controller: a change of link state, reception of a magic packet, and reception of a matching sample frame. Each request arrives as a one-cycle strobe. Each source has an enable bit of its own and a sticky status bit that records that the event was taken. Any accepted event also sets a power-management event status flag. That flag sets whether or not PME signalling is enabled.

Two outputs carry the wake indication off chip. The first is an active-low, open-drain power-management event line, modelled as a level plus a drive-enable. The second is a separate wake line. Three strap inputs are captured while reset is held. They choose, for each output, between a fixed-length pulse per event and a level held until software clears the status, and they set the polarity of the wake line.

A small control/status register holds the PME enable bit, a write-1-to-clear PME status bit and a two-bit power-state field. It is written through plain strobe-qualified pins. All pins are plain control and status signals, with no data stream and no handshake. The register access protocol and the event detection logic lie outside this block.

Top module: `wake_pme_ctrl`

## Requirements
- R1: While reset is held and after it is released: all event enables and event status bits are 0, pme_status is 0, pme_en is 0, pm_state is 00, pme_n is 1 with pme_oe 0, and wol_out sits at its idle level.
- R2: A strobe on a source whose enable bit is 1 sets that source's status bit and pme_status from the next cycle. The bit order in evt_en, wake_en_wdata and evt_status is: bit 0 link change, bit 1 sample frame, bit 2 magic packet. The bits stay set until cleared.
- R3: A strobe on a source whose enable bit is 0 changes neither its status bit, nor pme_status, nor either output.
- R4: pme_status sets regardless of pme_en. pme_n is driven low only while pme_en is 1. Writing pme_en to 0 releases pme_n in the next cycle.
- R5: A register write with pm_wdata_clr = 1 clears pme_status and all three event status bits. An event accepted in that same cycle still sets its bits.
- R6: A register write stores pm_wdata_state only when the value is 00 (D0) or 11 (D3hot). The values 01 and 10 leave pm_state unchanged.
- R7: In pulse mode, each accepted event makes the output active for PULSE_LEN cycles (default 16), starting with the cycle after the strobe. A new event during a pulse restarts the count.
- R8: In level mode, the output is active from the cycle after an accepted event for as long as pme_status stays 1.
- R9: With strap_wol_low = 0 the wake line idles low and is active high. With strap_wol_low = 1 it idles high and is active low. The wake line does not depend on pme_en.
- R10: The straps are sampled on every clock edge that sees reset asserted and keep their values after reset is released. Strap changes after release have no effect.
- R11: pme_oe is 1 exactly when pme_n is 0, which models an open-drain pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_pme_level | input | 1 | Strap: 0 = PME pulse mode, 1 = PME level mode |
| strap_wol_level | input | 1 | Strap: 0 = wake pulse mode, 1 = wake level mode |
| strap_wol_low | input | 1 | Strap: 0 = wake active high, 1 = wake active low |
| evt_link | input | 1 | One-cycle strobe: link status changed |
| evt_frame | input | 1 | One-cycle strobe: sample frame received |
| evt_magic | input | 1 | One-cycle strobe: magic packet received |
| wake_en_we | input | 1 | Write strobe for the event enable bits |
| wake_en_wdata | input | 3 | New enable bits (0 link, 1 frame, 2 magic) |
| pm_we | input | 1 | Write strobe for the PM control/status register |
| pm_wdata_pme_en | input | 1 | New PME enable value |
| pm_wdata_clr | input | 1 | 1 clears PME status and event status |
| pm_wdata_state | input | 2 | New power state (00 D0, 11 D3hot) |
| evt_en | output | 3 | Current event enable bits |
| evt_status | output | 3 | Sticky event status bits |
| pme_status | output | 1 | PME status flag |
| pme_en | output | 1 | PME enable bit |
| pm_state | output | 2 | Power-state field |
| pme_n | output | 1 | Active-low PME level |
| pme_oe | output | 1 | Open-drain pull-down enable for PME |
| wol_out | output | 1 | Wake output |

## Verification
The hardest case to reach from the ports is an event that lands in the same cycle as a status clear, or one that arrives partway through a running pulse. Both depend on the exact cycle of the strobe relative to the register write. The stimulus places the strobe and the clear write on the same negative edge. It also issues a second event eight cycles into a pulse and measures the total active length. Three reset sessions with different strap sets cover the mixed case: a PME pulse alongside a wake level of inverted polarity. Strap pins are changed after release to show they are ignored.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  typedef struct packed {
    logic pme_level;
    logic wol_level;
    logic wol_low;
  } strap_t;
endpackage

// File: rtl/wake_strap_capture.sv
module wake_strap_capture
  import wake_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  strap_t strap_in,
  output strap_t strap_q
);
  // Follows the pins while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end
endmodule

// File: rtl/wake_event_latch.sv
module wake_event_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic         clr,
  output logic [N-1:0] en_q,
  output logic [N-1:0] status_q,
  output logic         any_accept
);
  logic [N-1:0] accept;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic en_bit;
    logic st_bit;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_bit <= 1'b0;
        st_bit <= 1'b0;
      end else begin
        if (en_we) en_bit <= en_wdata[i];
        if (accept[i])  st_bit <= 1'b1;
        else if (clr)   st_bit <= 1'b0;
      end
    end
    assign accept[i]   = evt[i] & en_bit;
    assign en_q[i]     = en_bit;
    assign status_q[i] = st_bit;
  end

  assign any_accept = |accept;
endmodule

// File: rtl/wake_pm_csr.sv
module wake_pm_csr
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       wr_pme_en,
  input  logic       wr_clr,
  input  logic [1:0] wr_state,
  input  logic       any_accept,
  output logic       pme_status,
  output logic       pme_en,
  output logic [1:0] pm_state
);
  logic state_ok;
  assign state_ok = (wr_state == PS_D0) || (wr_state == PS_D3HOT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pme_status <= 1'b0;
      pme_en     <= 1'b0;
      pm_state   <= PS_D0;
    end else begin
      if (any_accept)          pme_status <= 1'b1;
      else if (we && wr_clr)   pme_status <= 1'b0;
      if (we) pme_en <= wr_pme_en;
      if (we && state_ok) pm_state <= wr_state;
    end
  end
endmodule

// File: rtl/wake_shaper.sv
module wake_shaper #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  input  logic level_mode,
  input  logic level_hold,
  output logic active
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (trigger)     cnt <= CW'(PULSE_LEN);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active = level_mode ? level_hold : (cnt != '0);
endmodule

// File: rtl/wake_pme_ctrl.sv
module wake_pme_ctrl
  import wake_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_pme_level,
  input  logic       strap_wol_level,
  input  logic       strap_wol_low,
  input  logic       evt_link,
  input  logic       evt_frame,
  input  logic       evt_magic,
  input  logic       wake_en_we,
  input  logic [2:0] wake_en_wdata,
  input  logic       pm_we,
  input  logic       pm_wdata_pme_en,
  input  logic       pm_wdata_clr,
  input  logic [1:0] pm_wdata_state,
  output logic [2:0] evt_en,
  output logic [2:0] evt_status,
  output logic       pme_status,
  output logic       pme_en,
  output logic [1:0] pm_state,
  output logic       pme_n,
  output logic       pme_oe,
  output logic       wol_out
);
  strap_t straps_in, straps;
  logic   any_accept;
  logic   pme_active, wol_active;
  logic   clr;

  assign straps_in = '{pme_level: strap_pme_level,
                       wol_level: strap_wol_level,
                       wol_low:   strap_wol_low};
  assign clr = pm_we & pm_wdata_clr;

  wake_strap_capture u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(straps_in), .strap_q(straps)
  );

  wake_event_latch #(.N(NUM_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .evt({evt_magic, evt_frame, evt_link}),
    .en_we(wake_en_we), .en_wdata(wake_en_wdata), .clr(clr),
    .en_q(evt_en), .status_q(evt_status), .any_accept(any_accept)
  );

  wake_pm_csr u_csr (
    .clk(clk), .rst_n(rst_n), .we(pm_we),
    .wr_pme_en(pm_wdata_pme_en), .wr_clr(pm_wdata_clr),
    .wr_state(pm_wdata_state), .any_accept(any_accept),
    .pme_status(pme_status), .pme_en(pme_en), .pm_state(pm_state)
  );

  wake_shaper #(.PULSE_LEN(PULSE_LEN)) u_pme_shape (
    .clk(clk), .rst_n(rst_n), .trigger(any_accept),
    .level_mode(straps.pme_level), .level_hold(pme_status),
    .active(pme_active)
  );

  wake_shaper #(.PULSE_LEN(PULSE_LEN)) u_wol_shape (
    .clk(clk), .rst_n(rst_n), .trigger(any_accept),
    .level_mode(straps.wol_level), .level_hold(pme_status),
    .active(wol_active)
  );

  logic pull_low;
  assign pull_low = pme_en & pme_active;
  assign pme_oe   = pull_low;
  assign pme_n    = ~pull_low;
  assign wol_out  = wol_active ^ straps.wol_low;
endmodule

// File: rtl/wake_pme_checker.sv
module wake_pme_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_link,
  input logic       evt_frame,
  input logic       evt_magic,
  input logic       pm_we,
  input logic       pm_wdata_clr,
  input logic [2:0] evt_en,
  input logic [2:0] evt_status,
  input logic       pme_status,
  input logic       pme_en,
  input logic [1:0] pm_state,
  input logic       pme_n
);
  logic any_acc;
  assign any_acc = (evt_link & evt_en[0]) | (evt_frame & evt_en[1]) |
                   (evt_magic & evt_en[2]);

  // R2
  a_r2_accept_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_magic && evt_en[2]) |=> (evt_status[2] && pme_status));

  // R3
  a_r3_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_link && !evt_en[0] && !(pm_we && pm_wdata_clr)) |=> $stable(evt_status[0]));

  // R4
  a_r4_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_en |-> pme_n);

  // R4
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_we && pme_en && !pme_n) |=> (pme_en || pme_n));

  // R5
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_we && pm_wdata_clr && !any_acc) |=> (!pme_status && evt_status == 3'b000));

  // R6
  a_r6_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'b00) || (pm_state == 2'b11));
endmodule

bind wake_pme_ctrl wake_pme_checker u_chk (
  .clk(clk), .rst_n(rst_n), .evt_link(evt_link), .evt_frame(evt_frame),
  .evt_magic(evt_magic), .pm_we(pm_we), .pm_wdata_clr(pm_wdata_clr),
  .evt_en(evt_en), .evt_status(evt_status), .pme_status(pme_status),
  .pme_en(pme_en), .pm_state(pm_state), .pme_n(pme_n)
);

// File: tb/test_wake_pme_ctrl.sv
module test_wake_pme_ctrl;
  localparam int PL = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic s_pl = 0, s_wl = 0, s_wlow = 0;
  logic e_link = 0, e_frame = 0, e_magic = 0;
  logic en_we = 0; logic [2:0] en_wd = 0;
  logic pm_we = 0, wd_en = 0, wd_clr = 0; logic [1:0] wd_st = 0;
  logic [2:0] evt_en, evt_status;
  logic pme_status, pme_en, pme_n, pme_oe, wol_out;
  logic [1:0] pm_state;

  wake_pme_ctrl #(.PULSE_LEN(PL)) i_wake_pme_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_pme_level(s_pl), .strap_wol_level(s_wl),
    .strap_wol_low(s_wlow), .evt_link(e_link), .evt_frame(e_frame),
    .evt_magic(e_magic), .wake_en_we(en_we), .wake_en_wdata(en_wd),
    .pm_we(pm_we), .pm_wdata_pme_en(wd_en), .pm_wdata_clr(wd_clr),
    .pm_wdata_state(wd_st), .evt_en(evt_en), .evt_status(evt_status),
    .pme_status(pme_status), .pme_en(pme_en), .pm_state(pm_state),
    .pme_n(pme_n), .pme_oe(pme_oe), .wol_out(wol_out)
  );

  int checks = 0, fails = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_en[3], m_st[3];
  int m_pst, m_pen, m_state, m_cnt_p, m_cnt_w;
  bit m_pl, m_wl, m_wlow;
  bit started = 0;

  always @(posedge clk) begin
    int acc;
    int evv[3];
    evv[0] = e_link; evv[1] = e_frame; evv[2] = e_magic;
    started <= 1;
    if (!rst_n) begin
      foreach (m_en[i]) begin m_en[i] = 0; m_st[i] = 0; end
      m_pst = 0; m_pen = 0; m_state = 0; m_cnt_p = 0; m_cnt_w = 0;
      m_pl = s_pl; m_wl = s_wl; m_wlow = s_wlow;
    end else begin
      acc = 0;
      for (int i = 0; i < 3; i++) if (evv[i] && m_en[i]) acc = 1;
      if (pm_we && wd_clr) begin
        m_pst = 0;
        for (int i = 0; i < 3; i++) m_st[i] = 0;
      end
      for (int i = 0; i < 3; i++) if (evv[i] && m_en[i]) m_st[i] = 1;
      if (acc) m_pst = 1;
      if (pm_we) begin
        m_pen = wd_en;
        if (wd_st == 2'b00 || wd_st == 2'b11) m_state = wd_st;
      end
      if (en_we) for (int i = 0; i < 3; i++) m_en[i] = en_wd[i];
      if (acc) begin m_cnt_p = PL; m_cnt_w = PL; end
      else begin
        if (m_cnt_p > 0) m_cnt_p--;
        if (m_cnt_w > 0) m_cnt_w--;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      int pact, wact, exp_pn;
      pact = m_pl ? m_pst : (m_cnt_p > 0);
      wact = m_wl ? m_pst : (m_cnt_w > 0);
      exp_pn = !(m_pen && pact);
      for (int i = 0; i < 3; i++) begin
        chk("R2 evt_status", evt_status[i], m_st[i]);
        chk("R1 evt_en", evt_en[i], m_en[i]);
      end
      chk("R4 pme_status", pme_status, m_pst);
      chk("R4 pme_en", pme_en, m_pen);
      chk("R6 pm_state", pm_state, m_state);
      chk("R4 pme_n", pme_n, exp_pn);
      chk("R11 pme_oe", pme_oe, !exp_pn);
      chk("R9 wol_out", wol_out, wact ^ m_wlow);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(bit l, bit f, bit m);
    e_link = l; e_frame = f; e_magic = m;
    tick();
    e_link = 0; e_frame = 0; e_magic = 0;
  endtask

  task automatic pm_write(bit en, bit clr, logic [1:0] st);
    pm_we = 1; wd_en = en; wd_clr = clr; wd_st = st;
    tick();
    pm_we = 0; wd_clr = 0;
  endtask

  task automatic en_write(logic [2:0] v);
    en_we = 1; en_wd = v;
    tick();
    en_we = 0;
  endtask

  task automatic do_reset(bit pl, bit wl, bit wlow);
    rst_n = 0; s_pl = pl; s_wl = wl; s_wlow = wlow;
    tick(3);
    rst_n = 1;
    tick();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // ---- session 1: pulse mode, active-high wake
    rst_n = 0; tick(2);
    chk("R1 reset pme_n", pme_n, 1);
    chk("R1 reset wol_out", wol_out, 0);
    chk("R1 reset status", evt_status, 0);
    chk("R1 reset pm_state", pm_state, 0);
    rst_n = 1; tick();
    s_pl = 1; s_wl = 1; s_wlow = 1;   // R10: ignored after release
    strobe(1, 1, 1); tick();
    chk("R3 disabled status", evt_status, 0);
    chk("R3 disabled pme_status", pme_status, 0);
    chk("R3 disabled wol", wol_out, 0);
    en_write(3'b111);
    strobe(1, 0, 0);
    chk("R2 link status", evt_status, 3'b001);
    chk("R4 status without enable", pme_status, 1);
    chk("R4 pme idle when disabled", pme_n, 1);
    n = 0;
    while (wol_out == 1 && n < 100) begin n++; tick(); end
    chk("R7 wol pulse length", n, PL);
    chk("R10 straps frozen wol idle", wol_out, 0);
    pm_write(1, 0, 2'b11);
    chk("R6 D3hot stored", pm_state, 3);
    pm_write(1, 0, 2'b01);
    chk("R6 illegal state ignored", pm_state, 3);
    strobe(0, 0, 1);
    chk("R4 pme asserted", pme_n, 0);
    tick(7);
    strobe(0, 1, 0);
    n = 0;
    while (pme_n == 0 && n < 100) begin n++; tick(); end
    chk("R7 retrigger length", n, PL);
    strobe(0, 0, 1);
    chk("R4 pme on", pme_n, 0);
    pm_write(0, 0, 2'b11);
    chk("R4 pme released", pme_n, 1);
    pm_write(1, 1, 2'b00);
    chk("R5 clear status", evt_status, 0);
    chk("R5 clear pme_status", pme_status, 0);
    chk("R6 D0 stored", pm_state, 0);
    e_link = 1;
    pm_write(1, 1, 2'b00);
    e_link = 0;
    chk("R5 event wins over clear", pme_status, 1);
    chk("R5 event bit kept", evt_status, 3'b001);
    tick(20);

    // ---- session 2: level modes, active-low wake
    do_reset(1, 1, 1);
    chk("R9 active-low idle high", wol_out, 1);
    chk("R1 pme released", pme_n, 1);
    en_write(3'b111);
    pm_write(1, 0, 2'b00);
    strobe(0, 1, 0);
    tick(30);
    chk("R8 pme level held", pme_n, 0);
    chk("R8 wol level held", wol_out, 0);
    pm_write(0, 0, 2'b00);
    chk("R4 pme released in level", pme_n, 1);
    chk("R9 wol independent of pme_en", wol_out, 0);
    pm_write(0, 1, 2'b00);
    chk("R8 wol drops on clear", wol_out, 1);

    // ---- session 3: PME pulse, wake level active high
    do_reset(0, 1, 0);
    en_write(3'b100);
    pm_write(1, 0, 2'b00);
    strobe(0, 0, 1);
    tick(20);
    chk("R7 pme pulse ended", pme_n, 1);
    chk("R8 wol level held", wol_out, 1);
    pm_write(1, 1, 2'b00);
    chk("R8 wol cleared", wol_out, 0);
    tick(3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule